// File: doc/BRIEF.md
# Monitored-Clock Frequency Meter

This block measures one of several monitored clocks against a free-running reference clock. Software selects a channel and a target number of monitored cycles in a control word. It sets a free-run permission bit in a monitor word, then raises an enable bit. The block counts reference cycles while the chosen clock completes the target number of its own cycles. It then sets a valid flag and freezes the count. The monitored frequency follows as f_mon = (target / result) × f_ref.

The reference domain holds the registers, the reference counter and the start and stop logic. Each monitored channel has a small counter in its own clock domain. A request level goes to the selected channel through a two-flop synchronizer and stays asserted for the whole run. The channel reports completion by flipping a done toggle, which is synchronized back to the reference domain. If the selected clock is dead, the reference counter stops at all-ones and valid stays low. Software is then expected to give up after its own timeout.

Top module: `clkmon_meter`

## Requirements
- R1: After reset, reads of the control word (offset 0x00), the result word (offset 0x0C) and the monitor word (offset 0x10) all return zero.
- R2: In the control word, bits [23:0] hold the target count, bit 24 is the enable and bits [27:26] are the channel select. All other control bits read as zero. Monitor bit 8 is the writable free-run permission. A write to the result word has no effect.
- R3: Monitor bit 0 is the valid flag. Writes do not change it. It is low while a measurement is in progress and goes high when the measurement completes.
- R4: For a target N and a monitored period Tm, with reference period Tr, the result lies between N·Tm/Tr and (N+4)·Tm/Tr + 5.
- R5: The channel select decides which monitored clock is measured, and only that channel is started.
- R6: A target of zero is measured as a target of one.
- R7: No measurement runs while the free-run bit is clear: valid and the result stay zero. Setting the free-run bit while enable is already set starts a measurement.
- R8: Clearing the enable bit clears valid and returns the result to zero. Setting the enable bit again starts a fresh measurement.
- R9: If the selected clock does not toggle, the result saturates at all-ones of its width and valid stays low.
- R10: While valid and enable stay set, the result does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| mon_clk | input | NCH | Monitored clocks, one per channel |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
The main function is tried on four monitored clocks with periods of 4, 10, 24 and 14 ns. Targets range from 0 to 200. Each result must land in a window narrow enough to separate the channels and to catch an off-by-one in the target comparison. A target of zero tells apart "one cycle" from a counter that wraps. Separate directed runs cover these cases:
- enable set while free-run is clear, then free-run set afterwards;
- an abort in the middle of a run, followed by a restart;
- a stopped clock, which must leave the result saturated with valid low.

// File: rtl/fm_pkg.sv
// Shared constants of the frequency meter: register offsets and field positions.
// Assumes byte offsets on a 5-bit address and a 32-bit data word.
package fm_pkg;
    localparam int ADDR_W        = 5;
    localparam int DATA_W        = 32;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RES  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_MON  = 5'h10;
    localparam int CTL_EN_BIT    = 24;
    localparam int CTL_SEL_LSB   = 26;
    localparam int MON_FRUN_BIT  = 8;
    localparam int MON_VALID_BIT = 0;
endpackage

// File: rtl/fm_sync2.sv
// Two-flop synchronizer for slowly changing levels.
// Assumes each input bit is a level or a toggle that is held for at least two destination clocks.
module fm_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Move the input into the clk domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fm_regs.sv
// Register file of the meter, in the reference domain.
// Assumes single-cycle writes and combinational reads; the valid flag and the result come from the controller.
module fm_regs
    import fm_pkg::*;
#(
    parameter int TGT_W = 24,
    parameter int SEL_W = 2,
    parameter int REF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              valid_i,
    input  logic [REF_W-1:0]  result_i,
    output logic [TGT_W-1:0]  target_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              en_o,
    output logic              frun_o
);
    logic unused_wd;
    assign unused_wd = ^wdata;

    // Capture software writes to the control and monitor words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_o <= '0;
            sel_o    <= '0;
            en_o     <= 1'b0;
            frun_o   <= 1'b0;
        end else if (wen) begin
            if (addr == OFS_CTRL) begin
                target_o <= wdata[TGT_W-1:0];
                sel_o    <= wdata[CTL_SEL_LSB +: SEL_W];
                en_o     <= wdata[CTL_EN_BIT];
            end else if (addr == OFS_MON) begin
                frun_o   <= wdata[MON_FRUN_BIT];
            end
        end
    end

    // Assemble the read word for the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[TGT_W-1:0]               = target_o;
                rdata[CTL_SEL_LSB +: SEL_W]    = sel_o;
                rdata[CTL_EN_BIT]              = en_o;
            end
            OFS_RES: rdata = DATA_W'(result_i);
            OFS_MON: begin
                rdata[MON_FRUN_BIT]  = frun_o;
                rdata[MON_VALID_BIT] = valid_i;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fm_mon_chan.sv
// Counter of one monitored channel, clocked by that channel's clock.
// Assumes the request level stays low for at least four monitored cycles between runs,
// and the target is stable from the request rise until completion.
module fm_mon_chan #(
    parameter int TGT_W = 24
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [TGT_W-1:0] target_i,
    output logic             done_tgl_o
);
    logic             req_s, req_d;
    logic             run_q;
    logic [TGT_W-1:0] cnt_q;
    logic [TGT_W:0]   nxt;

    fm_sync2 #(.W(1)) u_req_sync (
        .clk (mon_clk),
        .rst_n(rst_n),
        .d   (req_i),
        .q   (req_s)
    );

    assign nxt = {1'b0, cnt_q} + (TGT_W+1)'(1);

    // Start on a request rise, count monitored cycles, flip done at the target.
    always_ff @(posedge mon_clk) begin
        if (!rst_n) begin
            req_d      <= 1'b0;
            run_q      <= 1'b0;
            cnt_q      <= '0;
            done_tgl_o <= 1'b0;
        end else begin
            req_d <= req_s;
            if (!req_s) begin
                run_q <= 1'b0;
            end else if (!req_d) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (run_q) begin
                cnt_q <= nxt[TGT_W-1:0];
                if (nxt >= {1'b0, target_i}) begin
                    run_q      <= 1'b0;
                    done_tgl_o <= ~done_tgl_o;
                end
            end
        end
    end

    AST_DONE_IN_RUN: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (done_tgl_o != $past(done_tgl_o)) |-> $past(run_q && req_s)); // R4
endmodule

// File: rtl/fm_ref_ctl.sv
// Reference-domain controller: starts and aborts runs, counts reference cycles and detects completion.
// Assumes select and target are not changed by software while a run is in progress.
module fm_ref_ctl #(
    parameter int NCH   = 4,
    parameter int SEL_W = 2,
    parameter int TGT_W = 24,
    parameter int REF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             frun_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [TGT_W-1:0] target_i,
    input  logic [NCH-1:0]   done_tgl_i,
    output logic [NCH-1:0]   req_o,
    output logic [TGT_W-1:0] target_o,
    output logic             valid_o,
    output logic [REF_W-1:0] count_o
);
    logic             go, go_q;
    logic [SEL_W-1:0] lsel_q;
    logic [NCH-1:0]   dsync, dprev;
    logic             done_seen;
    logic [NCH-1:0]   sel_1h;

    fm_sync2 #(.W(NCH)) u_done_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (done_tgl_i),
        .q    (dsync)
    );

    assign go        = en_i & frun_i;
    assign done_seen = dsync[lsel_q] ^ dprev[lsel_q];
    assign sel_1h    = NCH'(1) << sel_i;

    // Remember the last synchronized done level of every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) dprev <= '0;
        else        dprev <= dsync;
    end

    // Run control: abort on loss of go, start on its rise, count until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q     <= 1'b0;
            req_o    <= '0;
            count_o  <= '0;
            valid_o  <= 1'b0;
            lsel_q   <= '0;
            target_o <= '0;
        end else begin
            go_q <= go;
            if (!go) begin
                req_o   <= '0;
                count_o <= '0;
                valid_o <= 1'b0;
            end else if (!go_q) begin
                req_o    <= sel_1h;
                count_o  <= '0;
                valid_o  <= 1'b0;
                lsel_q   <= sel_i;
                target_o <= target_i;
            end else if (|req_o) begin
                if (done_seen) begin
                    req_o   <= '0;
                    valid_o <= 1'b1;
                end else if (!(&count_o)) begin
                    count_o <= count_o + REF_W'(1);
                end
            end
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (&count_o) |=> ((&count_o) || !go_q || valid_o)); // R9
    AST_VALID_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (en_i || go_q)); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && go) |=> $stable(count_o)); // R10
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_o)); // R5
endmodule

// File: rtl/clkmon_meter.sv
// Top of the frequency meter: registers, reference controller and one counter per monitored clock.
// Assumes NCH is at most four and REF_W at most 32; rst_n is held over several cycles of every clock.
module clkmon_meter
    import fm_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TGT_W = 24,
    parameter int REF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    mon_clk,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [TGT_W-1:0] target, target_lat;
    logic [SEL_W-1:0] sel;
    logic             en, frun, valid;
    logic [REF_W-1:0] count;
    logic [NCH-1:0]   req, done_tgl;

    fm_regs #(.TGT_W(TGT_W), .SEL_W(SEL_W), .REF_W(REF_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wen     (reg_wen),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .valid_i (valid),
        .result_i(count),
        .target_o(target),
        .sel_o   (sel),
        .en_o    (en),
        .frun_o  (frun)
    );

    fm_ref_ctl #(.NCH(NCH), .SEL_W(SEL_W), .TGT_W(TGT_W), .REF_W(REF_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .frun_i    (frun),
        .sel_i     (sel),
        .target_i  (target),
        .done_tgl_i(done_tgl),
        .req_o     (req),
        .target_o  (target_lat),
        .valid_o   (valid),
        .count_o   (count)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        fm_mon_chan #(.TGT_W(TGT_W)) u_chan (
            .mon_clk   (mon_clk[ch]),
            .rst_n     (rst_n),
            .req_i     (req[ch]),
            .target_i  (target_lat),
            .done_tgl_o(done_tgl[ch])
        );
    end
endmodule

// File: tb/clkmon_meter_test.sv
`timescale 1ns/1ps
module clkmon_meter_test;
    localparam int RW = 12;
    localparam int NV = 5;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 1};
    localparam int V_TGT [NV] = '{100, 200, 50, 60, 0};
    localparam int PER   [4]  = '{4, 10, 24, 14};

    logic clk = 1'b0, rst_n = 1'b0;
    logic mc0 = 1'b0, mc1 = 1'b0, mc2 = 1'b0, mc3 = 1'b0;
    logic ch3_run = 1'b1;
    logic [3:0]  mon_clk;
    logic        reg_wen = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always #2 mc0 = ~mc0;
    always #5 mc1 = ~mc1;
    always #12 mc2 = ~mc2;
    always begin #7; if (ch3_run) mc3 = ~mc3; end
    assign mon_clk = {mc3, mc2, mc1, mc0};

    clkmon_meter #(.NCH(4), .TGT_W(24), .REF_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk),
        .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_valid(output bit got);
        logic [31:0] d;
        got = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            rd(5'h10, d);
            if (d[0]) begin got = 1'b1; break; end
        end
    endtask

    task automatic chk_range(input string req, input int res, input int tgt, input int per);
        real neff, lo, hi;
        neff = (tgt == 0) ? 1.0 : real'(tgt);
        lo = neff * per / 8.0;
        hi = (neff + 4.0) * per / 8.0 + 5.0;
        chk((real'(res) >= lo) && (real'(res) <= hi), req, res, longint'(lo));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, r1, r2;
        bit got;
        repeat (10) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(5'h0C, d); chk(d == 0, "R1 result", d, 0);
        rd(5'h10, d); chk(d == 0, "R1 monitor", d, 0);

        // R2 field layout with free-run clear so nothing starts
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d); chk(d == 32'h0DFF_FFFF, "R2 ctrl fields", d, 32'h0DFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, d); chk(d == 0, "R2 result read-only", d, 0);
        wr(5'h00, 32'h0);

        // R7 enable without free-run does nothing
        wr(5'h00, 32'h0100_0000 | 32'd100);
        repeat (200) @(posedge clk);
        rd(5'h10, d); chk(d[0] == 1'b0, "R7 no valid without free-run", d[0], 0);
        rd(5'h0C, d); chk(d == 0, "R7 no count without free-run", d, 0);
        // R3 valid is read-only; R7 setting free-run starts the pending run
        wr(5'h10, 32'h0000_0101);
        rd(5'h10, d); chk(d[0] == 1'b0, "R3 valid low while measuring", d[0], 0);
        chk(d[8] == 1'b1, "R2 free-run bit", d[8], 1);
        wait_valid(got); chk(got, "R7 run after free-run set", got, 1);
        rd(5'h0C, d); chk_range("R7 result", int'(d), 100, PER[0]);

        // Vector table: channel select and target against channel period (R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            wr(5'h00, (32'(V_SEL[v]) << 26) | 32'(V_TGT[v]));
            wr(5'h00, (32'(V_SEL[v]) << 26) | 32'h0100_0000 | 32'(V_TGT[v]));
            if (V_TGT[v] >= 10) begin
                rd(5'h10, d); chk(d[0] == 1'b0, "R3 valid low in run", d[0], 0);
            end
            wait_valid(got); chk(got, "R3 valid rises", got, 1);
            rd(5'h0C, d);
            if (V_TGT[v] == 0) chk_range("R6 zero target", int'(d), 0, PER[V_SEL[v]]);
            else               chk_range("R4 R5 result window", int'(d), V_TGT[v], PER[V_SEL[v]]);
        end

        // R10 result held while valid and enable stay set
        rd(5'h0C, r1);
        repeat (30) @(posedge clk);
        rd(5'h0C, r2); chk(r1 == r2, "R10 result stable", r2, r1);

        // R8 abort mid-run, then restart
        wr(5'h00, (32'd2 << 26) | 32'd1000);
        wr(5'h00, (32'd2 << 26) | 32'h0100_0000 | 32'd1000);
        repeat (40) @(posedge clk);
        rd(5'h0C, d); chk(d > 0, "R8 counting before abort", d, 1);
        wr(5'h00, (32'd2 << 26) | 32'd20);
        rd(5'h0C, d); chk(d == 0, "R8 result cleared", d, 0);
        rd(5'h10, d); chk(d[0] == 1'b0, "R8 valid cleared", d[0], 0);
        repeat (20) @(posedge clk);
        wr(5'h00, (32'd2 << 26) | 32'h0100_0000 | 32'd20);
        wait_valid(got); chk(got, "R8 restart completes", got, 1);
        rd(5'h0C, d); chk_range("R8 fresh result", int'(d), 20, PER[2]);

        // R9 dead clock saturates
        wr(5'h00, (32'd3 << 26) | 32'd10);
        ch3_run = 1'b0;
        repeat (20) @(posedge clk);
        wr(5'h00, (32'd3 << 26) | 32'h0100_0000 | 32'd10);
        repeat (4300) @(posedge clk);
        rd(5'h0C, d); chk(d == 32'hFFF, "R9 saturated count", d, 32'hFFF);
        rd(5'h10, d); chk(d[0] == 1'b0, "R9 valid stays low", d[0], 0);
        wr(5'h00, 32'h0);
        rd(5'h0C, d); chk(d == 0, "R8 clear after saturation", d, 0);
        ch3_run = 1'b1;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule